// File: doc/BRIEF.md
# ADC Result Readout Port

This block is the digital output stage of a 16-bit converter. Each finished conversion arrives as a parallel word with a one-cycle valid strobe. The block holds that word and presents it to a host in one of two forms. With the mode input low, all sixteen bits appear on a parallel bus. With the mode input high, three of the bus pins are reused as a serial clock, a frame sync and a read-error flag, and the word leaves on a separate serial data line, most significant bit first.

The serial port has two clocking choices. In the internal choice the block generates the bit clock by dividing its system clock and marks the frame with a sync level of selectable polarity. In the external (slave) choice the host supplies the bit clock on the shared pin. An edge-invert input selects which clock edge moves the data in both choices. A combined chip-select and read pair, each active low and merged with an OR, enables the pins and starts a serial read when the pair becomes active. In slave mode, if a conversion completes while a read is still running, the unread word is discarded, the new word is loaded and the error pin pulses.

Top module: `adc_readout_port`

## Requirements
- R1: With serial mode off and both enable inputs low, every bus pin is enabled (bus_oe_o = 16'hFFFF) and bus_o equals the held result word.
- R2: When cs_n_i or rd_n_i is high, bus_oe_o is all zeros in every mode.
- R3: In serial mode, pins 0 to 8 are disabled, while pins 12 to 15 stay enabled and carry result bits 15:12 in both modes.
- R4: In serial mode, pin 9 carries the generated bit clock and is enabled when internal clocking is chosen (ext_clk_i = 0), and is disabled (an input) when external clocking is chosen.
- R5: A serial frame sends the held word on sdout_o, bit 15 first, 16 bits per frame. The internal bit clock has a period of SCLK_DIV system clocks, and an internal frame lasts 16 x SCLK_DIV cycles.
- R6: With edge_inv_i = 0 the serial data changes only on falling edges of the bit clock and is stable over rising edges; with edge_inv_i = 1 the roles of the edges swap. This holds for the generated clock on pin 9 and for the clock received on sclk_i.
- R7: With internal clocking, pin 10 is at its active level for exactly the frame and at its inactive level otherwise; the active level is high when sync_inv_i = 0 and low when sync_inv_i = 1.
- R8: With external clocking, a conversion that completes during a read aborts the read, loads the new word (its bit 15 appears on sdout_o at once) and pulses pin 11 high for exactly one cycle.
- R9: With internal clocking, a conversion that completes during a frame is ignored: the frame finishes with the old word, the held word is unchanged and pin 11 stays low.
- R10: If an external update edge and a completing conversion fall in the same cycle, the overrun wins: no shift is applied and the new word is loaded whole.
- R11: After reset the held word is zero, no read is running and pin 11 is low.
- R12: A conversion is loaded whenever no read is running, and a serial read starts each time the enable pair becomes active; a new read starts again from bit 15 of the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| result_i | input | 16 | Converted word |
| result_valid_i | input | 1 | One-cycle strobe: conversion complete |
| ser_mode_i | input | 1 | 0 parallel, 1 serial |
| ext_clk_i | input | 1 | Serial clocking: 0 internal, 1 external |
| edge_inv_i | input | 1 | Selects the data update edge of the bit clock |
| sync_inv_i | input | 1 | Selects the active level of the frame sync |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read, active low |
| sclk_i | input | 1 | Bit clock from the host in external mode |
| bus_o | output | 16 | Shared bus pin values |
| bus_oe_o | output | 16 | Per-pin drive enable (0 = high impedance) |
| sdout_o | output | 1 | Serial data |

## Verification
The collision that matters is a completing conversion landing in the same cycle as a slave-mode shift edge: both want to write the shift register and the read counter. The bench provokes it by moving sclk_i to its update level one edge before raising the valid strobe, so that the synchronised edge and the strobe are sampled by the same clock edge. It judges the outcome at the pins: exactly one error pulse, bit 15 of the new word on sdout_o straight after, and a following full read that returns the new word unshifted.

// File: rtl/adc_rdo_pkg.sv
package adc_rdo_pkg;

   typedef enum logic [2:0] {
      ROLE_LOW,
      ROLE_CLK,
      ROLE_SYNC,
      ROLE_ERR,
      ROLE_HIGH
   } pin_role_e;

   // The three shared pins sit in a row starting at clk_bit.
   function automatic pin_role_e role_of(input int idx, input int clk_bit);
      if (idx < clk_bit)          return ROLE_LOW;
      else if (idx == clk_bit)    return ROLE_CLK;
      else if (idx == clk_bit+1)  return ROLE_SYNC;
      else if (idx == clk_bit+2)  return ROLE_ERR;
      else                        return ROLE_HIGH;
   endfunction

endpackage

// File: rtl/rdo_clkgen.sv
module rdo_clkgen #(
   parameter int SCLK_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic ext_i,
   input  logic edge_inv_i,
   input  logic run_i,
   input  logic sclk_i,
   output logic tick_o,
   output logic sclk_pin_o
);
   localparam int HALF = SCLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] div_cnt;
   logic          raw;
   logic          s1, s2;
   logic          wrap;

   assign wrap = (div_cnt == CW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         div_cnt <= '0;
         raw     <= 1'b0;
         s1      <= 1'b0;
         s2      <= 1'b0;
      end else begin
         s1 <= sclk_i;
         s2 <= s1;
         if (!run_i || ext_i) begin
            div_cnt <= '0;
            raw     <= 1'b0;
         end else if (wrap) begin
            div_cnt <= '0;
            raw     <= ~raw;
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   // Update edge: falling edge of the raw clock (internal) or the
   // synchronised host clock reaching the level equal to edge_inv_i.
   always_comb begin
      if (ext_i) tick_o = run_i && (s1 != s2) && (s1 == edge_inv_i);
      else       tick_o = run_i && wrap && raw;
   end

   assign sclk_pin_o = raw ^ edge_inv_i;

   p_tick_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
      tick_o |-> run_i);

   p_ext_clk_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (ext_i && $past(ext_i)) |-> !raw);

endmodule

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_i,
   input  logic              ext_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              start_i,
   input  logic              tick_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] word_o,
   output logic              sdout_o,
   output logic              err_o
);
   localparam int BW = $clog2(DATA_W);
   localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [BW-1:0]     bit_cnt;
   logic              ovr;
   logic              load;

   assign ovr  = valid_i && busy_o && ser_i && ext_i;
   assign load = valid_i && (!busy_o || ovr);

   always_ff @(posedge clk) begin
      if (rst) begin
         word_o  <= '0;
         shreg   <= '0;
         bit_cnt <= '0;
         busy_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         err_o <= ovr;
         if (load) word_o <= data_i;
         if (ovr) begin
            busy_o  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= data_i;
         end else if (start_i) begin
            busy_o  <= 1'b1;
            bit_cnt <= '0;
            shreg   <= load ? data_i : word_o;
         end else if (busy_o && tick_i) begin
            shreg   <= shreg << 1;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) busy_o <= 1'b0;
         end else if (load) begin
            shreg   <= data_i;
         end
      end
   end

   assign sdout_o = shreg[DATA_W-1];

   p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
      err_o |=> !err_o);

   p_abort_on_err_r10: assert property (@(posedge clk) disable iff (rst)
      err_o |-> !busy_o);

   p_full_frame_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy_o) && !err_o) |-> ($past(bit_cnt) == LAST && $past(tick_i)));

   p_start_only_r12: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/rdo_pinmux.sv
module rdo_pinmux
   import adc_rdo_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CLK_BIT = 9
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic              sclk_pin_i,
   input  logic              sync_lvl_i,
   input  logic              err_i,
   input  logic              ser_i,
   input  logic              ext_i,
   input  logic              en_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] oe_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      localparam pin_role_e ROLE = role_of(i, CLK_BIT);
      if (ROLE == ROLE_LOW) begin : g_low
         assign bus_o[i] = word_i[i];
         assign oe_o[i]  = en_i && !ser_i;
      end else if (ROLE == ROLE_CLK) begin : g_clk
         assign bus_o[i] = ser_i ? sclk_pin_i : word_i[i];
         assign oe_o[i]  = en_i && !(ser_i && ext_i);
      end else if (ROLE == ROLE_SYNC) begin : g_sync
         assign bus_o[i] = ser_i ? sync_lvl_i : word_i[i];
         assign oe_o[i]  = en_i;
      end else if (ROLE == ROLE_ERR) begin : g_err
         assign bus_o[i] = ser_i ? err_i : word_i[i];
         assign oe_o[i]  = en_i;
      end else begin : g_high
         assign bus_o[i] = word_i[i];
         assign oe_o[i]  = en_i;
      end
   end
endmodule

// File: rtl/adc_readout_port.sv
module adc_readout_port #(
   parameter int DATA_W   = 16,
   parameter int CLK_BIT  = 9,
   parameter int SCLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] result_i,
   input  logic              result_valid_i,
   input  logic              ser_mode_i,
   input  logic              ext_clk_i,
   input  logic              edge_inv_i,
   input  logic              sync_inv_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              sclk_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] bus_oe_o,
   output logic              sdout_o
);
   if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
      $error("SCLK_DIV must be even and at least 2");
   end
   if (DATA_W < CLK_BIT + 4) begin : g_bad_width
      $error("DATA_W too small for the shared pin group");
   end

   logic en, en_q, start, busy, tick, sclk_pin, sync_lvl, err;
   logic [DATA_W-1:0] word;

   assign en    = !(cs_n_i || rd_n_i);
   assign start = ser_mode_i && en && !en_q && !busy;

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= en;
   end

   assign sync_lvl = (busy && !ext_clk_i) ^ sync_inv_i;

   rdo_clkgen #(.SCLK_DIV(SCLK_DIV)) u_clk (
      .clk(clk), .rst(rst), .ext_i(ext_clk_i), .edge_inv_i(edge_inv_i),
      .run_i(busy), .sclk_i(sclk_i), .tick_o(tick), .sclk_pin_o(sclk_pin)
   );

   rdo_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst(rst), .ser_i(ser_mode_i), .ext_i(ext_clk_i),
      .valid_i(result_valid_i), .data_i(result_i), .start_i(start),
      .tick_i(tick), .busy_o(busy), .word_o(word), .sdout_o(sdout_o),
      .err_o(err)
   );

   rdo_pinmux #(.DATA_W(DATA_W), .CLK_BIT(CLK_BIT)) u_mux (
      .word_i(word), .sclk_pin_i(sclk_pin), .sync_lvl_i(sync_lvl),
      .err_i(err), .ser_i(ser_mode_i), .ext_i(ext_clk_i), .en_i(en),
      .bus_o(bus_o), .oe_o(bus_oe_o)
   );

   p_bus_off_r2: assert property (@(posedge clk) disable iff (rst)
      (cs_n_i || rd_n_i) |-> (bus_oe_o == '0));

   p_err_slave_only_r8: assert property (@(posedge clk) disable iff (rst)
      err |-> $past(ser_mode_i && ext_clk_i && result_valid_i));

endmodule

// File: tb/adc_readout_port_test.sv
module adc_readout_port_test;
   localparam int W   = 16;
   localparam int DIV = 4;

   logic clk = 0, rst = 1;
   logic [W-1:0] result = '0;
   logic valid = 0, ser = 0, ext = 0, inv = 0, sinv = 0;
   logic cs_n = 1, rd_n = 1, sclk = 0;
   logic [W-1:0] bus, oe;
   logic sdout;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   adc_readout_port #(.DATA_W(W), .CLK_BIT(9), .SCLK_DIV(DIV)) uut (
      .clk(clk), .rst(rst), .result_i(result), .result_valid_i(valid),
      .ser_mode_i(ser), .ext_clk_i(ext), .edge_inv_i(inv), .sync_inv_i(sinv),
      .cs_n_i(cs_n), .rd_n_i(rd_n), .sclk_i(sclk),
      .bus_o(bus), .bus_oe_o(oe), .sdout_o(sdout)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [W-1:0] w);
      @(negedge clk); result = w; valid = 1;
      @(negedge clk); valid = 0;
   endtask

   task automatic idle_bus();
      @(negedge clk); cs_n = 1; rd_n = 1;
      repeat (3) @(negedge clk);
   endtask

   // R11: reset state
   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(oe == 0, "R2 idle after reset", oe, 0);
      cs_n = 0; rd_n = 0;
      @(negedge clk);
      chk(bus == 0, "R11 word zero", bus, 0);
      chk(oe == 16'hFFFF, "R1 oe parallel", oe, 16'hFFFF);
      idle_bus();
   endtask

   // R1, R2, R3, R12: parallel bus
   task automatic t_parallel();
      ser = 0;
      load(16'h1234);
      cs_n = 0; rd_n = 0;
      @(negedge clk);
      chk(bus == 16'h1234, "R1 bus word", bus, 16'h1234);
      rd_n = 1;
      @(negedge clk);
      chk(oe == 0, "R2 rd high", oe, 0);
      rd_n = 0; cs_n = 1;
      @(negedge clk);
      chk(oe == 0, "R2 cs high", oe, 0);
      cs_n = 0;
      load(16'hBEEF);
      @(negedge clk);
      chk(bus == 16'hBEEF, "R12 reload while idle", bus, 16'hBEEF);
      chk(bus[15:12] == 4'hB, "R3 upper bits parallel", bus[15:12], 4'hB);
      idle_bus();
   endtask

   // R4 R5 R6 R7 R9 R12: internal-clock frame
   task automatic t_int_frame(input logic e_inv, input logic s_inv,
                              input logic [W-1:0] w, input int inject,
                              input logic [W-1:0] w2);
      logic [W-1:0] cap = '0;
      int ncap = 0, act = 0, bad = 0, errs = 0;
      logic prev_pin, prev_sd, pin;
      ser = 1; ext = 0; inv = e_inv; sinv = s_inv;
      load(w);
      @(negedge clk);
      prev_pin = bus[9]; prev_sd = sdout;
      cs_n = 0; rd_n = 0;
      for (int c = 0; c < 16*DIV + 8; c++) begin
         @(negedge clk);
         pin = bus[9];
         if (bus[10] == !s_inv) act++;
         if (pin != prev_pin && pin == !e_inv) begin cap = {cap[W-2:0], sdout}; ncap++; end
         if (sdout != prev_sd && !(pin != prev_pin && pin == e_inv)) bad++;
         if (bus[11]) errs++;
         if (c == 2) chk(oe == 16'hFE00, "R4 oe internal serial", oe, 16'hFE00);
         prev_pin = pin; prev_sd = sdout;
         result = w2; valid = (c == inject);
      end
      valid = 0;
      chk(cap == w && ncap == 16, "R5 frame word", {cap, 16'(ncap)}, {w, 16'd16});
      chk(act == 16*DIV, "R7 sync duration", act, 16*DIV);
      chk(bad == 0, "R6 update edge internal", bad, 0);
      chk(bus[10] == s_inv, "R7 sync inactive", bus[10], s_inv);
      if (inject >= 0) begin
         chk(errs == 0, "R9 no error internal", errs, 0);
         idle_bus(); ser = 0; cs_n = 0; rd_n = 0;
         @(negedge clk);
         chk(bus == w, "R9 held word kept", bus, w);
      end
      idle_bus();
   endtask

   task automatic ext_read(output logic [W-1:0] got, output int bad);
      got = '0; bad = 0;
      @(negedge clk); cs_n = 0; rd_n = 0;
      repeat (2) @(negedge clk);
      for (int b = 0; b < W; b++) begin
         logic pre;
         pre = sdout;
         got = {got[W-2:0], sdout};
         sclk = !inv;
         repeat (4) @(negedge clk);
         if (sdout != pre) bad++;
         sclk = inv;
         repeat (4) @(negedge clk);
      end
   endtask

   // R3 R4 R6: external-clock read
   task automatic t_ext_frame(input logic e_inv, input logic [W-1:0] w);
      logic [W-1:0] got; int bad;
      ser = 1; ext = 1; inv = e_inv; sclk = e_inv;
      load(w);
      ext_read(got, bad);
      chk(got == w, "R5 ext word", got, w);
      chk(bad == 0, "R6 ext update edge", bad, 0);
      chk(oe == 16'hFC00, "R3 R4 oe ext serial", oe, 16'hFC00);
      chk(bus[15:12] == w[15:12], "R3 upper bits serial", bus[15:12], w[15:12]);
      idle_bus();
      ext_read(got, bad);
      chk(got == w, "R12 reread from bit 15", got, w);
      idle_bus();
   endtask

   // R8 (collide=0) and R10 (collide=1)
   task automatic t_overrun(input bit collide, input logic [W-1:0] a,
                            input logic [W-1:0] b);
      int pulses = 0; logic [W-1:0] got; int bad;
      string tag;
      tag = collide ? "R10" : "R8";
      ser = 1; ext = 1; inv = 0; sclk = 0;
      load(a);
      @(negedge clk); cs_n = 0; rd_n = 0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         sclk = 1; repeat (4) @(negedge clk);
         sclk = 0; repeat (4) @(negedge clk);
      end
      if (collide) begin
         sclk = 1; repeat (4) @(negedge clk);
         sclk = 0;
         @(negedge clk);
      end
      result = b; valid = 1;
      @(negedge clk); valid = 0;
      for (int c = 0; c < 4; c++) begin
         if (bus[11]) pulses++;
         if (c == 0) chk(sdout == b[W-1], {tag, " new msb at once"}, sdout, b[W-1]);
         @(negedge clk);
      end
      chk(pulses == 1, {tag, " one error pulse"}, pulses, 1);
      idle_bus();
      ext_read(got, bad);
      chk(got == b, {tag, " new word after overrun"}, got, b);
      idle_bus();
   endtask

   initial begin
      t_reset();
      t_parallel();
      t_int_frame(0, 0, 16'hA5C3, -1, 16'h0);
      t_int_frame(1, 1, 16'h3C69, -1, 16'h0);
      t_int_frame(0, 1, 16'h9B1E, 20, 16'h4444);
      t_ext_frame(0, 16'hC35A);
      t_ext_frame(1, 16'h6D2B);
      t_overrun(0, 16'hF0F0, 16'h0F0F);
      t_overrun(1, 16'hFFFF, 16'h5A5A);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule